// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit with Signed-Overflow Trap Flag

This block is the combinational execute-stage datapath of a load/store RISC integer core. It takes two register operands, an optional 16-bit immediate, a 5-bit constant shift amount and a 5-bit operation code. In the same cycle it returns a 32-bit result and a flag that tells the core to raise an arithmetic-overflow exception.

The operation set has two add/subtract flavours. The trapping flavour flags two's-complement overflow. The non-trapping flavour returns the same bits and never flags. The block also provides signed and unsigned compare-to-bit operations, four bitwise operations, six shifts and an upper-immediate load. Of the six shifts, three take a constant amount and three take the amount from register A. When `use_imm` is high, the immediate replaces operand B for the add/subtract, compare and bitwise groups. It is zero-extended for the bitwise group and sign-extended for the others.

The block has no state, so the house state-machine layout collapses to a single selection step. The operation code is decoded into a named enumeration. One `unique case` then picks among four sub-units: the operand selector, the adder/subtractor, the bitwise unit and the barrel shifter.

Top module: `int_alu`

## Requirements
- R1: Code 0 (trapping add) returns A+B and code 2 (trapping subtract) returns A-B, both modulo 2^32. `ovf_trap` is 1 exactly when the signed result does not fit in 32 bits.
- R2: Code 1 (add) and code 3 (subtract) return the same modulo-2^32 value as codes 0 and 2, with `ovf_trap` held at 0.
- R3: Code 4 returns 1 when A<B as two's-complement numbers, else 0. Code 5 does the same with an unsigned comparison. Bits 31:1 of the result are always 0, and neither code raises `ovf_trap`, even when the internal subtraction overflows.
- R4: Codes 6, 7, 8 and 9 return A AND B, A OR B, A XOR B and NOT(A OR B), bit by bit.
- R5: With `use_imm`=1, `imm_val` replaces B for codes 0 to 9. It is sign-extended (bit 15 copied into bits 31:16) for codes 0 to 5 and zero-extended for codes 6 to 9.
- R6: Code 10 shifts B left by `shamt` and code 11 shifts B right by `shamt`, both with zero fill. Code 12 shifts B right by `shamt`, filling with copies of B[31]. A shift amount of 0 returns B unchanged.
- R7: Codes 13, 14 and 15 shift B left-logical, right-logical and right-arithmetic by A[4:0]. A[31:5] and `shamt` have no effect.
- R8: Code 16 returns `imm_val` in bits 31:16 and zeros in bits 15:0, whatever the values of A and B.
- R9: Codes 17 to 31 return 0. `ovf_trap` is 0 for every code other than 0 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code (see requirements) |
| use_imm | input | 1 | Substitute the extended immediate for operand B |
| opnd_a | input | 32 | First register operand; low bits give the variable shift amount |
| opnd_b | input | 32 | Second register operand; the value shifted by all shifts |
| imm_val | input | 16 | Instruction immediate |
| shamt | input | 5 | Constant shift amount |
| result | output | 32 | Operation result |
| ovf_trap | output | 1 | Signed-overflow exception request |

## Verification
The add/subtract paths are tried with operand pairs on both sides of the sign boundary: positive+positive, negative+negative, mixed signs, and a carry-out without signed overflow. These pairs show whether the overflow rule depends on the operand signs rather than on the carry. Each pair is repeated in the non-trapping codes to confirm the flag is masked there. The compares use an operand pair whose order flips between signed and unsigned interpretation, and a pair whose internal difference overflows. Shifts are swept over every amount with a sign-set input, which distinguishes arithmetic from logical fill. Variable shifts are given operands with junk in A[31:5] to show that only the low five bits count.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD_T  = 5'd0,
        OP_ADD_W  = 5'd1,
        OP_SUB_T  = 5'd2,
        OP_SUB_W  = 5'd3,
        OP_LT_S   = 5'd4,
        OP_LT_U   = 5'd5,
        OP_AND    = 5'd6,
        OP_OR     = 5'd7,
        OP_XOR    = 5'd8,
        OP_NOR    = 5'd9,
        OP_SHL_K  = 5'd10,
        OP_SHR_K  = 5'd11,
        OP_SAR_K  = 5'd12,
        OP_SHL_V  = 5'd13,
        OP_SHR_V  = 5'd14,
        OP_SAR_V  = 5'd15,
        OP_UPPER  = 5'd16
    } op_e;

    typedef enum logic [1:0] {
        BW_AND = 2'd0,
        BW_OR  = 2'd1,
        BW_XOR = 2'd2,
        BW_NOR = 2'd3
    } bw_e;

endpackage

// File: rtl/int_alu_opnd.sv
// Chooses operand B or the extended immediate (R5).
module int_alu_opnd #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [XLEN-1:0]  reg_b,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    input  logic             zero_ext,
    output logic [XLEN-1:0]  b_eff
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_ext;

    always_comb begin
        if (zero_ext) begin
            imm_ext = {{EXT_W{1'b0}}, imm};
        end else begin
            imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        end
        b_eff = use_imm ? imm_ext : reg_b;
    end
endmodule

// File: rtl/int_alu_addsub.sv
// Shared adder/subtractor: sum, signed overflow and both less-than bits (R1, R2, R3).
module int_alu_addsub #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            sub,
    output logic [XLEN-1:0] sum,
    output logic            sgn_ovf,
    output logic            lt_s,
    output logic            lt_u
);
    localparam int MSB = XLEN - 1;

    logic [XLEN-1:0] b_x;
    logic            c_out;

    always_comb begin
        b_x            = b ^ {XLEN{sub}};
        {c_out, sum}   = {1'b0, a} + {1'b0, b_x} + {{XLEN{1'b0}}, sub};
        sgn_ovf        = (a[MSB] == b_x[MSB]) && (sum[MSB] != a[MSB]);
        lt_s           = sum[MSB] ^ sgn_ovf;
        lt_u           = ~c_out;
    end
endmodule

// File: rtl/int_alu_bitwise.sv
// Bitwise group (R4).
module int_alu_bitwise #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]      a,
    input  logic [XLEN-1:0]      b,
    input  int_alu_pkg::bw_e     fn,
    output logic [XLEN-1:0]      y
);
    import int_alu_pkg::*;

    always_comb begin
        unique case (fn)
            BW_AND:  y = a & b;
            BW_OR:   y = a | b;
            BW_XOR:  y = a ^ b;
            BW_NOR:  y = ~(a | b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/int_alu_shift.sv
// Log-depth barrel shifter; left shifts reuse the right-shift stages
// by reversing the bit order on entry and exit (R6, R7).
module int_alu_shift #(
    parameter int XLEN = 32,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] din,
    input  logic [SHW-1:0]  amt,
    input  logic            to_left,
    input  logic            arith,
    output logic [XLEN-1:0] dout
);
    localparam int MSB = XLEN - 1;

    logic [XLEN-1:0] din_rev;
    logic [XLEN-1:0] src;
    logic [XLEN-1:0] res_rev;
    logic [XLEN-1:0] stage [SHW+1];
    logic            fill;

    for (genvar k = 0; k < XLEN; k++) begin : g_rev_in
        assign din_rev[k] = din[MSB-k];
        assign res_rev[k] = stage[SHW][MSB-k];
    end

    assign fill     = arith & ~to_left & din[MSB];
    assign src      = to_left ? din_rev : din;
    assign stage[0] = src;

    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int STEP = 1 << i;
        assign stage[i+1] = amt[i] ? {{STEP{fill}}, stage[i][MSB:STEP]} : stage[i];
    end

    assign dout = to_left ? res_rev : stage[SHW];
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    localparam int SHW  = $clog2(XLEN)
) (
    input  logic [OPW-1:0]   op_sel,
    input  logic             use_imm,
    input  logic [XLEN-1:0]  opnd_a,
    input  logic [XLEN-1:0]  opnd_b,
    input  logic [IMM_W-1:0] imm_val,
    input  logic [SHW-1:0]   shamt,
    output logic [XLEN-1:0]  result,
    output logic             ovf_trap
);
    localparam int LOW_W = XLEN - IMM_W;

    op_e             op;
    logic            is_bitwise;
    logic            do_sub;
    logic [XLEN-1:0] b_eff;
    logic [XLEN-1:0] sum;
    logic            sgn_ovf;
    logic            lt_s;
    logic            lt_u;
    bw_e             bw_fn;
    logic [XLEN-1:0] bw_y;
    logic [SHW-1:0]  sh_amt;
    logic            sh_left;
    logic            sh_arith;
    logic [XLEN-1:0] sh_y;

    assign op = op_e'(op_sel);

    // Decode step: control lines for each sub-unit.
    always_comb begin
        is_bitwise = 1'b0;
        do_sub     = 1'b0;
        bw_fn      = BW_AND;
        sh_amt     = shamt;
        sh_left    = 1'b0;
        sh_arith   = 1'b0;
        unique case (op)
            OP_SUB_T, OP_SUB_W, OP_LT_S, OP_LT_U: do_sub = 1'b1;
            OP_AND: begin is_bitwise = 1'b1; bw_fn = BW_AND; end
            OP_OR:  begin is_bitwise = 1'b1; bw_fn = BW_OR;  end
            OP_XOR: begin is_bitwise = 1'b1; bw_fn = BW_XOR; end
            OP_NOR: begin is_bitwise = 1'b1; bw_fn = BW_NOR; end
            OP_SHL_K: sh_left = 1'b1;
            OP_SAR_K: sh_arith = 1'b1;
            OP_SHL_V: begin sh_left = 1'b1; sh_amt = opnd_a[SHW-1:0]; end
            OP_SHR_V: sh_amt = opnd_a[SHW-1:0];
            OP_SAR_V: begin sh_arith = 1'b1; sh_amt = opnd_a[SHW-1:0]; end
            default: ;
        endcase
    end

    int_alu_opnd #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opnd (
        .reg_b    (opnd_b),
        .imm      (imm_val),
        .use_imm  (use_imm),
        .zero_ext (is_bitwise),
        .b_eff    (b_eff)
    );

    int_alu_addsub #(.XLEN(XLEN)) u_addsub (
        .a       (opnd_a),
        .b       (b_eff),
        .sub     (do_sub),
        .sum     (sum),
        .sgn_ovf (sgn_ovf),
        .lt_s    (lt_s),
        .lt_u    (lt_u)
    );

    int_alu_bitwise #(.XLEN(XLEN)) u_bitwise (
        .a  (opnd_a),
        .b  (b_eff),
        .fn (bw_fn),
        .y  (bw_y)
    );

    int_alu_shift #(.XLEN(XLEN), .SHW(SHW)) u_shift (
        .din     (opnd_b),
        .amt     (sh_amt),
        .to_left (sh_left),
        .arith   (sh_arith),
        .dout    (sh_y)
    );

    // Output step: result select and trap qualification (R1, R2, R9).
    always_comb begin
        result   = '0;
        ovf_trap = 1'b0;
        unique case (op)
            OP_ADD_T, OP_SUB_T: begin
                result   = sum;
                ovf_trap = sgn_ovf;
            end
            OP_ADD_W, OP_SUB_W:          result = sum;
            OP_LT_S:                     result = {{(XLEN-1){1'b0}}, lt_s};
            OP_LT_U:                     result = {{(XLEN-1){1'b0}}, lt_u};
            OP_AND, OP_OR, OP_XOR, OP_NOR: result = bw_y;
            OP_SHL_K, OP_SHR_K, OP_SAR_K,
            OP_SHL_V, OP_SHR_V, OP_SAR_V: result = sh_y;
            OP_UPPER:                    result = {imm_val, {LOW_W{1'b0}}};
            default: begin
                result   = '0;
                ovf_trap = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input logic [4:0]       op_sel,
    input logic             use_imm,
    input logic [XLEN-1:0]  opnd_a,
    input logic [XLEN-1:0]  opnd_b,
    input logic [IMM_W-1:0] imm_val,
    input logic [XLEN-1:0]  result,
    input logic             ovf_trap
);
    localparam int MSB = XLEN - 1;

    always_comb begin
        assert_trap_codes_only_R9: assert (!ovf_trap || op_sel == 5'd0 || op_sel == 5'd2)
            else $error("trap flag on non-trapping code %0d", op_sel);

        if (op_sel == 5'd1 || op_sel == 5'd3) begin
            assert_no_overflow_R2: assert (!ovf_trap)
                else $error("wrapping add/sub raised trap");
        end

        if (op_sel == 5'd4 || op_sel == 5'd5) begin
            assert_cmp_is_bit_R3: assert (result[MSB:1] == '0)
                else $error("compare result wider than one bit");
        end

        if (op_sel == 5'd16) begin
            assert_upper_layout_R8: assert (result[MSB:XLEN-IMM_W] == imm_val && result[XLEN-IMM_W-1:0] == '0)
                else $error("upper-immediate layout wrong");
        end

        if (op_sel > 5'd16) begin
            assert_unused_zero_R9: assert (result == '0 && !ovf_trap)
                else $error("unused code produced output");
        end

        if (op_sel == 5'd9 && !use_imm) begin
            assert_nor_disjoint_R4: assert ((result & (opnd_a | opnd_b)) == '0)
                else $error("NOR result overlaps an input one");
        end

        if (op_sel == 5'd0 && !use_imm && ovf_trap) begin
            assert_ovf_signs_R1: assert (opnd_a[MSB] == opnd_b[MSB] && result[MSB] != opnd_a[MSB])
                else $error("trap on add without sign change");
        end
    end
endmodule

bind int_alu int_alu_chk #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (
    .op_sel   (op_sel),
    .use_imm  (use_imm),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .imm_val  (imm_val),
    .result   (result),
    .ovf_trap (ovf_trap)
);

// File: tb/sim_int_alu.sv
module sim_int_alu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op_sel = '0;
    logic        use_imm = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [15:0] imm_val = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] result;
    logic        ovf_trap;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    int_alu u0 (
        .op_sel   (op_sel),
        .use_imm  (use_imm),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .imm_val  (imm_val),
        .shamt    (shamt),
        .result   (result),
        .ovf_trap (ovf_trap)
    );

    // {req, op, imm_sel, A, B, imm, shamt, expected result, expected trap}
    localparam int NV = 37;
    localparam logic [127:0] VEC [NV] = '{
        {4'd1, 5'd0, 1'b0, 32'h0000_0005, 32'h0000_0007, 16'h0000, 5'd0, 32'h0000_000C, 1'b0},  // R1 plain
        {4'd1, 5'd0, 1'b0, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0000, 5'd0, 32'h8000_0000, 1'b1},  // R1 pos+pos
        {4'd1, 5'd0, 1'b0, 32'h8000_0000, 32'h8000_0000, 16'h0000, 5'd0, 32'h0000_0000, 1'b1},  // R1 neg+neg
        {4'd1, 5'd0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 5'd0, 32'h0000_0000, 1'b0},  // R1 carry only
        {4'd1, 5'd2, 1'b0, 32'h8000_0000, 32'h0000_0001, 16'h0000, 5'd0, 32'h7FFF_FFFF, 1'b1},  // R1 sub
        {4'd1, 5'd2, 1'b0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0000, 5'd0, 32'h8000_0000, 1'b1},  // R1 sub
        {4'd1, 5'd2, 1'b0, 32'h0000_0010, 32'h0000_0003, 16'h0000, 5'd0, 32'h0000_000D, 1'b0},  // R1 sub
        {4'd2, 5'd1, 1'b0, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0000, 5'd0, 32'h8000_0000, 1'b0},  // R2
        {4'd2, 5'd3, 1'b0, 32'h8000_0000, 32'h0000_0001, 16'h0000, 5'd0, 32'h7FFF_FFFF, 1'b0},  // R2
        {4'd2, 5'd3, 1'b0, 32'h0000_0000, 32'h0000_0001, 16'h0000, 5'd0, 32'hFFFF_FFFF, 1'b0},  // R2
        {4'd3, 5'd4, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 5'd0, 32'h0000_0001, 1'b0},  // R3 signed
        {4'd3, 5'd5, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 5'd0, 32'h0000_0000, 1'b0},  // R3 unsigned
        {4'd3, 5'd4, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0000, 5'd0, 32'h0000_0001, 1'b0},  // R3 ovf diff
        {4'd3, 5'd5, 1'b0, 32'h0000_0001, 32'h0000_0002, 16'h0000, 5'd0, 32'h0000_0001, 1'b0},  // R3
        {4'd3, 5'd4, 1'b0, 32'h0000_0005, 32'h0000_0005, 16'h0000, 5'd0, 32'h0000_0000, 1'b0},  // R3 equal
        {4'd4, 5'd6, 1'b0, 32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0000, 5'd0, 32'hF000_F000, 1'b0},  // R4
        {4'd4, 5'd7, 1'b0, 32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0000, 5'd0, 32'hFFF0_FFF0, 1'b0},  // R4
        {4'd4, 5'd8, 1'b0, 32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0000, 5'd0, 32'h0FF0_0FF0, 1'b0},  // R4
        {4'd4, 5'd9, 1'b0, 32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0000, 5'd0, 32'h000F_000F, 1'b0},  // R4
        {4'd5, 5'd0, 1'b1, 32'h0000_0010, 32'h1234_5678, 16'hFFFF, 5'd0, 32'h0000_000F, 1'b0},  // R5 sext
        {4'd5, 5'd6, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 16'h8001, 5'd0, 32'h0000_8001, 1'b0},  // R5 zext
        {4'd5, 5'd7, 1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 16'hFFFF, 5'd0, 32'h0000_FFFF, 1'b0},  // R5 zext
        {4'd5, 5'd4, 1'b1, 32'h0000_0000, 32'h0000_0005, 16'hFFFF, 5'd0, 32'h0000_0000, 1'b0},  // R5 signed cmp
        {4'd5, 5'd5, 1'b1, 32'h0000_0000, 32'h0000_0000, 16'hFFFF, 5'd0, 32'h0000_0001, 1'b0},  // R5 unsigned cmp
        {4'd5, 5'd1, 1'b1, 32'h0000_0000, 32'h0000_0000, 16'h8000, 5'd0, 32'hFFFF_8000, 1'b0},  // R5
        {4'd5, 5'd8, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 16'h8000, 5'd0, 32'hFFFF_7FFF, 1'b0},  // R5
        {4'd6, 5'd10, 1'b0, 32'h0000_0000, 32'h0000_0001, 16'h0000, 5'd31, 32'h8000_0000, 1'b0}, // R6
        {4'd6, 5'd11, 1'b0, 32'h0000_0000, 32'h8000_0000, 16'h0000, 5'd4, 32'h0800_0000, 1'b0},  // R6
        {4'd6, 5'd12, 1'b0, 32'h0000_0000, 32'h8000_0000, 16'h0000, 5'd4, 32'hF800_0000, 1'b0},  // R6
        {4'd6, 5'd12, 1'b0, 32'h0000_0000, 32'h4000_0000, 16'h0000, 5'd4, 32'h0400_0000, 1'b0},  // R6
        {4'd6, 5'd10, 1'b0, 32'h0000_0000, 32'hDEAD_BEEF, 16'h0000, 5'd0, 32'hDEAD_BEEF, 1'b0},  // R6 zero amt
        {4'd7, 5'd13, 1'b0, 32'hFFFF_FFE3, 32'h0000_0001, 16'h0000, 5'd9, 32'h0000_0008, 1'b0},  // R7
        {4'd7, 5'd14, 1'b0, 32'h0000_003F, 32'hFFFF_FFFF, 16'h0000, 5'd2, 32'h0000_0001, 1'b0},  // R7
        {4'd7, 5'd15, 1'b0, 32'h0000_0020, 32'h8000_0001, 16'h0000, 5'd7, 32'h8000_0001, 1'b0},  // R7
        {4'd8, 5'd16, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h1234, 5'd0, 32'h1234_0000, 1'b0},  // R8
        {4'd9, 5'd17, 1'b0, 32'h7FFF_FFFF, 32'h0000_0001, 16'hFFFF, 5'd3, 32'h0000_0000, 1'b0},  // R9
        {4'd9, 5'd31, 1'b0, 32'h8000_0000, 32'h8000_0000, 16'hFFFF, 5'd3, 32'h0000_0000, 1'b0}   // R9
    };

    task automatic apply(input logic [4:0] op, input logic im, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] iv, input logic [4:0] sh);
        @(negedge clk);
        op_sel  = op;
        use_imm = im;
        opnd_a  = a;
        opnd_b  = b;
        imm_val = iv;
        shamt   = sh;
        #1;
    endtask

    task automatic check(input int req, input logic [31:0] exp_r, input logic exp_o);
        checks++;
        if (result !== exp_r || ovf_trap !== exp_o) begin
            errors++;
            $display("FAIL R%0d op=%0d: result=%h trap=%b, expected result=%h trap=%b",
                     req, op_sel, result, ovf_trap, exp_r, exp_o);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Idle inputs: trapping add of zeros gives zero, no trap (R1).
        apply(5'd0, 1'b0, 32'h0, 32'h0, 16'h0, 5'd0);
        check(1, 32'h0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic [127:0] v;
            v = VEC[i];
            apply(v[123:119], v[118], v[117:86], v[85:54], v[53:38], v[37:33]);
            check(int'(v[127:124]), v[32:1], v[0]);
        end

        // R6: constant left shift of 1 over every amount.
        for (int s = 0; s < 32; s++) begin
            apply(5'd10, 1'b0, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'(s));
            check(6, 32'h1 << s, 1'b0);
        end

        // R7: arithmetic variable shift of the sign bit, junk in A upper bits.
        for (int s = 0; s < 32; s++) begin
            apply(5'd15, 1'b0, {27'h5A5A5A5, 5'(s)}, 32'h8000_0000, 16'h0, 5'd0);
            check(7, ~(32'hFFFF_FFFF >> (s + 1)), 1'b0);
        end

        // R7: logical variable right shift, constant field set but ignored.
        for (int s = 0; s < 32; s++) begin
            apply(5'd14, 1'b0, 32'(s), 32'h8000_0000, 16'h0, 5'd17);
            check(7, 32'h8000_0000 >> s, 1'b0);
        end

        // R8: upper load unaffected by the immediate-select line and operands.
        apply(5'd16, 1'b1, 32'h0, 32'h0, 16'hBEEF, 5'd31);
        check(8, 32'hBEEF_0000, 1'b0);

        // R9: every unused code gives zero with overflow-provoking operands.
        for (int c = 17; c < 32; c++) begin
            apply(5'(c), 1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 16'hFFFF, 5'd31);
            check(9, 32'h0, 1'b0);
        end

        // R2: wrapping add with overflowing operands via immediate path.
        apply(5'd1, 1'b1, 32'h8000_0000, 32'h0, 16'hFFFF, 5'd0);
        check(2, 32'h7FFF_FFFF, 1'b0);

        // R1: trapping add with sign-extended negative immediate overflows.
        apply(5'd0, 1'b1, 32'h8000_0000, 32'h0, 16'hFFFF, 5'd0);
        check(1, 32'h7FFF_FFFF, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule